// File: doc/BRIEF.md
# Two-Step Parallel Chien Search

This block finds the roots of a binary BCH error-locator polynomial Λ(x) = 1 + Y(x) over GF(2^M). Y(x) is the sum of λj·x^j for j = 1..T. A start pulse loads the T locator coefficients. The block then sweeps every codeword position in groups of P. Each clock it issues one P-bit flag vector, in which a set bit marks a position where Y(α^pos) equals 1.

Each candidate is tested in two pipelined steps:

- **Screening step.** This cheap step runs on every cycle. It computes only the low half of the bits of Y and compares them with the low half of the value 1.
- **Completing step.** This step works on the upper bits. Its operand registers load only for rows that pass the screen. Rows that miss the screen leave these registers unchanged, so that logic does not toggle.

The block also keeps a running count of flagged positions. A done pulse marks the last group.

In use, a key-equation solver supplies the coefficients and pulses start. A correction stage then reads the flag vectors together with the group index.

Top module: `two_step_chien`

## Requirements
- R1: While rst_ni is low, the outputs are held at zero: flags_o, flag_vld_o, group_o, err_cnt_o and done_o.
- R2: When start_i is sampled high while the block is idle, it captures lambda_i. Coefficient λj sits in bits [(j-1)·M +: M]. The field uses the primitive polynomial POLY (default x^8+x^4+x^3+x^2+1), and α is the element 0x02.
- R3: While flag_vld_o is high, bit i-1 of flags_o is 1 exactly when Λ(α^(group_o·P+i)) = 0 for a valid position. When flag_vld_o is low, flags_o is 0.
- R4: The groups 0 .. G-1, where G = ⌈N/P⌉, appear on consecutive cycles with flag_vld_o high and group_o equal to the group number. Group 0 appears after the second rising edge that follows the edge that accepted the start, and group w appears w cycles later.
- R5: A position above N (padding in the last group) is never flagged.
- R6: err_cnt_o clears when a start is accepted. On each valid cycle it adds the number of flags in that cycle, so its value includes the current flags_o. It holds between searches.
- R7: done_o is a one-cycle pulse that coincides with the last group. At that cycle err_cnt_o holds the total for the search.
- R8: A start_i pulse arriving while a search is in progress is ignored, along with its lambda_i. The block is busy from the accepting edge through the edge that raises done_o.
- R9: An all-zero locator (Y = 0) flags no position and leaves a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load coefficients and begin a sweep |
| lambda_i | input | T*M | Coefficients λ1..λT, λ1 in the low bits |
| flags_o | output | P | Error flags for positions group·P+1 .. group·P+P |
| flag_vld_o | output | 1 | flags_o and group_o are valid |
| group_o | output | GW | Group index of flags_o |
| err_cnt_o | output | CW | Running count of flagged positions |
| done_o | output | 1 | Last group of the sweep |

## Verification
The assertions check four things on every cycle:

- Group indices step by one while valid.
- The count advances by exactly the population of the current flags.
- Padding positions stay clear and flags stay zero outside valid cycles.
- Done coincides with the last group, and the sweep counter never runs without the busy state.

Only the bench's scenarios can show that the flags mark the true roots of Λ. It runs near-exhaustive sweeps of every position for many locators built from chosen error sets, together with arbitrary coefficients. The same scenarios cover the exact start-to-output latency, the final count, and the proof that a start arriving mid-sweep leaves results untouched.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned GF_MAXW = 16;
  typedef logic [GF_MAXW-1:0] gf_word_t;

  // shift-and-add product in GF(2^m); poly includes bit m
  function automatic gf_word_t gf_mul(gf_word_t a, gf_word_t b, int unsigned m, gf_word_t poly);
    gf_word_t acc = '0;
    gf_word_t x   = a;
    for (int unsigned k = 0; k < GF_MAXW; k++) begin
      if (k < m) begin
        if (b[k]) acc ^= x;
        x = x << 1;
        if (x[m]) x ^= poly;
      end
    end
    return acc;
  endfunction

  function automatic gf_word_t gf_alpha_pow(int unsigned e, int unsigned m, gf_word_t poly);
    gf_word_t r    = gf_word_t'(1);
    gf_word_t base = gf_word_t'(2);
    for (int unsigned k = 0; k < 32; k++) begin
      if (((e >> k) & 1) != 0) r = gf_mul(r, base, m, poly);
      base = gf_mul(base, base, m, poly);
    end
    return r;
  endfunction

  // constant multiply as bit-matrix product: XOR of columns c*alpha^b
  function automatic gf_word_t gf_cmul(gf_word_t x, gf_word_t c, int unsigned m, gf_word_t poly);
    gf_word_t r = '0;
    for (int unsigned b = 0; b < GF_MAXW; b++) begin
      if (b < m && x[b]) r ^= gf_mul(c, gf_word_t'(1) << b, m, poly);
    end
    return r;
  endfunction
endpackage

// File: rtl/cs_omega_bank.sv
module cs_omega_bank import cs_pkg::*; #(
  parameter int unsigned M    = 8,
  parameter int unsigned T    = 4,
  parameter int unsigned P    = 4,
  parameter gf_word_t    POLY = 16'h11D
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           adv_i,
  input  logic [T*M-1:0] lambda_i,
  output logic [T*M-1:0] omega_o
);
  for (genvar j = 1; j <= T; j++) begin : g_reg
    localparam gf_word_t STEP = gf_alpha_pow(P * j, M, POLY);
    logic [M-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     w_q <= '0;
      else if (load_i) w_q <= lambda_i[(j-1)*M +: M];
      else if (adv_i)  w_q <= M'(gf_cmul(gf_word_t'(w_q), STEP, M, POLY));
    end
    assign omega_o[(j-1)*M +: M] = w_q;
  end
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl #(
  parameter int unsigned G  = 64,
  parameter int unsigned GW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output logic          run_o,
  output logic [GW-1:0] grp_o,
  output logic          v1_o,
  output logic [GW-1:0] grp1_o,
  output logic          last1_o
);
  logic busy_q, run_q, v1_q, last1_q;
  logic [GW-1:0] grp_q, grp1_q;
  logic last_grp;

  assign load_o   = start_i & ~busy_q;
  assign last_grp = (grp_q == GW'(G - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; run_q <= 1'b0; grp_q <= '0;
      v1_q <= 1'b0; grp1_q <= '0; last1_q <= 1'b0;
    end else begin
      if (load_o) begin
        busy_q <= 1'b1; run_q <= 1'b1; grp_q <= '0;
      end else begin
        if (run_q) begin
          if (last_grp) run_q <= 1'b0;
          else          grp_q <= grp_q + 1'b1;
        end
        if (last1_q) busy_q <= 1'b0;
      end
      v1_q    <= run_q;
      grp1_q  <= grp_q;
      last1_q <= run_q & last_grp;
    end
  end

  assign run_o   = run_q;
  assign grp_o   = grp_q;
  assign v1_o    = v1_q;
  assign grp1_o  = grp1_q;
  assign last1_o = last1_q;

  // R8: a sweep only runs inside a busy window, so a new start cannot enter it
  p_run_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> busy_q);
endmodule

// File: rtl/cs_screen_row.sv
module cs_screen_row import cs_pkg::*; #(
  parameter int unsigned M    = 8,
  parameter int unsigned T    = 4,
  parameter int unsigned ROW  = 1,
  parameter int unsigned LO   = 4,
  parameter gf_word_t    POLY = 16'h11D
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [T*M-1:0] omega_i,
  output logic           hit_o
);
  localparam gf_word_t LO_MASK = gf_word_t'((1 << LO) - 1);
  localparam gf_word_t HI_MASK = gf_word_t'((1 << M) - 1) & ~LO_MASK;

  gf_word_t lo_acc, hi_acc;
  logic hit_d, hit_q;
  logic [T*M-1:0] op_q;

  // step 1: only the low slice survives the mask, so its cone is all that remains
  always_comb begin
    lo_acc = '0;
    for (int unsigned j = 1; j <= T; j++)
      lo_acc ^= gf_cmul(gf_word_t'(omega_i[(j-1)*M +: M]), gf_alpha_pow(ROW * j, M, POLY), M, POLY);
  end
  assign hit_d = en_i && ((lo_acc & LO_MASK) == gf_word_t'(1));

  // operand registers load only on a screening hit; otherwise step 2 stays quiet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      op_q  <= '0;
    end else begin
      hit_q <= hit_d;
      if (hit_d) op_q <= omega_i;
    end
  end

  // step 2: upper slice must be zero
  always_comb begin
    hi_acc = '0;
    for (int unsigned j = 1; j <= T; j++)
      hi_acc ^= gf_cmul(gf_word_t'(op_q[(j-1)*M +: M]), gf_alpha_pow(ROW * j, M, POLY), M, POLY);
  end
  assign hit_o = hit_q && ((hi_acc & HI_MASK) == '0);
endmodule

// File: rtl/two_step_chien.sv
module two_step_chien import cs_pkg::*; #(
  parameter int unsigned  M    = 8,
  parameter int unsigned  T    = 4,
  parameter int unsigned  P    = 4,
  parameter int unsigned  N    = 255,
  parameter gf_word_t     POLY = 16'h11D,
  localparam int unsigned G    = (N + P - 1) / P,
  localparam int unsigned GW   = (G > 1) ? $clog2(G) : 1,
  localparam int unsigned CW   = $clog2(N + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [T*M-1:0] lambda_i,
  output logic [P-1:0]   flags_o,
  output logic           flag_vld_o,
  output logic [GW-1:0]  group_o,
  output logic [CW-1:0]  err_cnt_o,
  output logic           done_o
);
  localparam int unsigned LO = (M + 1) / 2;

  function automatic logic [P-1:0] pad_mask_f();
    logic [P-1:0] mk = '0;
    for (int unsigned i = 0; i < P; i++)
      if ((G - 1) * P + i + 1 > N) mk[i] = 1'b1;
    return mk;
  endfunction
  localparam logic [P-1:0] PAD_MASK = pad_mask_f();

  logic load_w, run_w, v1_w, last1_w;
  logic [GW-1:0] grp_w, grp1_w;
  logic [T*M-1:0] omega_w;
  logic [P-1:0] en_w, hit_w;

  cs_ctrl #(.G(G), .GW(GW)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_o(load_w), .run_o(run_w), .grp_o(grp_w),
    .v1_o(v1_w), .grp1_o(grp1_w), .last1_o(last1_w)
  );

  cs_omega_bank #(.M(M), .T(T), .P(P), .POLY(POLY)) bank_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_w), .adv_i(run_w),
    .lambda_i(lambda_i), .omega_o(omega_w)
  );

  for (genvar r = 1; r <= P; r++) begin : g_row
    assign en_w[r-1] = run_w && ((32'(grp_w) * P + 32'(r)) <= N);
    cs_screen_row #(.M(M), .T(T), .ROW(r), .LO(LO), .POLY(POLY)) row_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w[r-1]),
      .omega_i(omega_w), .hit_o(hit_w[r-1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0; flag_vld_o <= 1'b0; group_o <= '0;
      err_cnt_o <= '0; done_o <= 1'b0;
    end else begin
      flags_o    <= v1_w ? hit_w : '0;
      flag_vld_o <= v1_w;
      group_o    <= grp1_w;
      done_o     <= last1_w;
      if (load_w)    err_cnt_o <= '0;
      else if (v1_w) err_cnt_o <= err_cnt_o + CW'($countones(hit_w));
    end
  end

  p_done_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_vld_o && group_o == GW'(G - 1));

  p_pad_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_vld_o && group_o == GW'(G - 1)) |-> (flags_o & PAD_MASK) == '0);

  p_cnt_accum_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_vld_o && $past(flag_vld_o)) |-> err_cnt_o == $past(err_cnt_o) + CW'($countones(flags_o)));

  p_grp_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_vld_o && $past(flag_vld_o)) |-> group_o == $past(group_o) + 1'b1);

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_vld_o |-> (flags_o == '0 && !done_o));
endmodule

// File: tb/two_step_chien_tb_top.sv
module two_step_chien_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int M = 8, T = 4, P = 4, N = 255, G = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [T*M-1:0] lambda = '0;
  logic [P-1:0]  flags;
  logic          vld, done;
  logic [5:0]    grp;
  logic [7:0]    cnt;

  int checks = 0, fails = 0;
  logic [P-1:0] exp_f [G];

  two_step_chien dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lambda_i(lambda),
    .flags_o(flags), .flag_vld_o(vld), .group_o(grp), .err_cnt_o(cnt), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = '0;
    logic [7:0] x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] bpow(int e);
    logic [7:0] r = 8'h01;
    for (int k = 0; k < e % 255; k++) r = bmul(r, 8'h02);
    return r;
  endfunction

  // Λ(x) = Π (1 + α^-e x)
  function automatic logic [31:0] build_lam(int k, int e0, int e1, int e2, int e3);
    logic [7:0] c [5];
    logic [31:0] out;
    int e;
    for (int i = 0; i < 5; i++) c[i] = '0;
    c[0] = 8'h01;
    for (int r = 0; r < k; r++) begin
      e = (r == 0) ? e0 : (r == 1) ? e1 : (r == 2) ? e2 : e3;
      for (int i = 4; i >= 1; i--) c[i] ^= bmul(bpow(255 - (e % 255)), c[i-1]);
    end
    for (int j = 1; j <= 4; j++) out[(j-1)*8 +: 8] = c[j];
    return out;
  endfunction

  task automatic make_expect(input logic [31:0] lam);
    logic [7:0] x, xp, s;
    for (int g = 0; g < G; g++) begin
      exp_f[g] = '0;
      for (int i = 1; i <= P; i++) begin
        if (g * P + i <= N) begin
          x = bpow(g * P + i); xp = 8'h01; s = 8'h01;
          for (int j = 1; j <= T; j++) begin
            xp = bmul(xp, x);
            s ^= bmul(lam[(j-1)*8 +: 8], xp);
          end
          exp_f[g][i-1] = (s == 8'h00);
        end
      end
    end
  endtask

  task automatic run_case(input logic [31:0] lam, input bit poke, input string req);
    int cum = 0;
    make_expect(lam);
    @(negedge clk); start = 1'b1; lambda = lam;
    @(negedge clk); start = 1'b0; lambda = ~lam;
    chk(vld == 1'b0, "R4", "vld one cycle after start", int'(vld), 0);
    @(negedge clk);
    chk(vld == 1'b0, "R4", "vld two cycles after start", int'(vld), 0);
    for (int g = 0; g < G; g++) begin
      @(negedge clk);
      cum += $countones(exp_f[g]);
      chk(vld == 1'b1 && grp == 6'(g), "R4", "group index", int'(grp), g);
      chk(flags == exp_f[g], req, $sformatf("flags group %0d", g), int'(flags), int'(exp_f[g]));
      chk(int'(cnt) == cum, "R6", "running count", int'(cnt), cum);
      chk(done == (g == G - 1), "R7", "done position", int'(done), int'(g == G - 1));
      if (g == G - 1) begin
        chk(flags[3] == 1'b0, "R5", "padding bit", int'(flags[3]), 0);
        chk(int'(cnt) == cum, "R7", "count at done", int'(cnt), cum);
      end
      if (poke && g == 10) begin start = 1'b1; lambda = 32'h0000_0001; end
      if (poke && g == 11) begin start = 1'b0; end
    end
    @(negedge clk);
    chk(vld == 1'b0 && done == 1'b0, "R7", "done is one pulse", int'(done), 0);
    chk(int'(cnt) == cum, "R6", "count holds", int'(cnt), cum);
    if (poke) chk(int'(cnt) == cum, "R8", "mid-sweep start ignored", int'(cnt), cum);
  endtask

  initial begin
    int e [4];
    int k;
    repeat (3) @(negedge clk);
    chk(flags == '0 && vld == 1'b0 && done == 1'b0 && cnt == '0 && grp == '0,
        "R1", "reset outputs", int'(flags) + int'(cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 1'b0 && cnt == '0, "R1", "idle after reset", int'(vld), 0);

    run_case(32'h0, 1'b0, "R9");
    run_case(build_lam(1, 77, 0, 0, 0), 1'b0, "R2");
    run_case(build_lam(4, 1, 2, 3, 4), 1'b0, "R3");
    run_case(build_lam(4, 252, 253, 254, 255), 1'b0, "R3");
    run_case(build_lam(1, 255, 0, 0, 0), 1'b0, "R3");
    run_case(build_lam(3, 1, 128, 200, 0), 1'b1, "R8");
    run_case(32'h1D_5A_03_C7, 1'b0, "R3");
    for (int s = 0; s < 14; s++) begin
      k = $urandom_range(0, 4);
      for (int r = 0; r < 4; r++) begin
        bit dup;
        do begin
          e[r] = $urandom_range(1, 255);
          dup = 1'b0;
          for (int q = 0; q < r; q++) if (e[q] == e[r]) dup = 1'b1;
        end while (dup);
      end
      run_case(build_lam(k, e[0], e[1], e[2], e[3]), 1'b0, "R3");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule